// File: doc/BRIEF.md
# Stacked Register Frame Marker

This block keeps the current frame marker of a stacked register file: the frame size, the locals size, the rotating size and the frame base within the stacked physical region. It also keeps the saved marker of the calling function. A single command port applies one frame operation per accepted command: load a whole frame, enter a callee, go back to the caller, grow the frame by an immediate count, or shrink it by an immediate count. Every accepted command gets exactly one response, which reports whether the operation was illegal.

The marker also holds a top-of-stack index, the physical slot just past the frame, kept modulo the stacked region size. A register-name translator can then address registers relative to the top of stack without a subtraction at access time. Its base and top-of-stack outputs come straight from registers. Spilling to memory, register data storage and instruction decode sit outside this block.

Top module: `rsfm_unit`

## Requirements
- R1: After reset the frame sizes, the base, the top of stack and the saved marker are all zero, no response is pending, and `cmd_ready` is high from the first clock edge after reset is released.
- R2: Opcode 0 (full allocate) loads frame size, locals size and rotating size from `cmd_sof`, `cmd_sol`, `cmd_sor` and keeps the base.
- R3: A full allocate faults when locals size exceeds frame size, when rotating size exceeds frame size, or when frame size exceeds STACK_REGS (96); on any fault the whole marker, saved marker included, is left unchanged.
- R4: Opcode 1 (call) copies the current marker into the saved marker, advances the base by the locals size, makes the new frame size the caller's frame size minus its locals size, and clears locals and rotating sizes.
- R5: Opcode 3 (grow) adds the 7-bit immediate `cmd_imm` to the frame size; it faults when the sum exceeds STACK_REGS.
- R6: Opcode 4 (shrink) subtracts the immediate from the frame size; it faults when the immediate exceeds the frame size, and a result of exactly zero is legal.
- R7: After a successful shrink, locals size and rotating size are each limited to the new frame size.
- R8: Opcode 2 (return) restores frame size, locals size, rotating size and base from the saved marker; it never faults.
- R9: The base advance wraps modulo STACK_REGS, and the top of stack always equals (base + frame size) modulo STACK_REGS.
- R10: Opcodes 5, 6 and 7 are undefined and fault without changing the marker.
- R11: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge; `rsp_valid` is high for exactly the following cycle, with `rsp_fault` for that command, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Operation code |
| cmd_imm | input | IMM_W | Grow or shrink count |
| cmd_sof | input | CNT_W | Frame size for full allocate |
| cmd_sol | input | CNT_W | Locals size for full allocate |
| cmd_sor | input | CNT_W | Rotating size for full allocate |
| rsp_valid | output | 1 | Response for the command taken on the previous edge |
| rsp_fault | output | 1 | The command was illegal and changed nothing |
| frame_sof | output | CNT_W | Current frame size |
| frame_sol | output | CNT_W | Current locals size |
| frame_sor | output | CNT_W | Current rotating size |
| frame_base | output | IDX_W | Current frame base |
| frame_tos | output | IDX_W | Current top-of-stack index |
| pfs_sof | output | CNT_W | Saved frame size |
| pfs_sol | output | CNT_W | Saved locals size |
| pfs_sor | output | CNT_W | Saved rotating size |
| pfs_base | output | IDX_W | Saved frame base |

## Verification
The assertions assume that commands arrive only while `cmd_ready` is high and that the fields of the saved marker obey the same bounds as the current one, which holds because the saved marker is only ever written from a legal current marker. The stimulus only raises `cmd_valid` after reset has been released and waits for `cmd_ready`, and it takes every field out of range only through the command fields, where the design must reject it. Calls are nested deep enough to drive the base past the end of the stacked region, so the wrap and the top-of-stack relation are exercised on a non-power-of-two size.

// File: rtl/rsfm_pkg.sv
package rsfm_pkg;

   typedef enum logic [2:0] {
      OP_ALLOC  = 3'd0,
      OP_CALL   = 3'd1,
      OP_RET    = 3'd2,
      OP_GROW   = 3'd3,
      OP_SHRINK = 3'd4
   } rsfm_op_e;

endpackage

// File: rtl/rsfm_wrap_add.sv
module rsfm_wrap_add #(
   parameter int N     = 96,
   parameter int IDX_W = 7,
   parameter int CNT_W = 7
) (
   input  logic [IDX_W-1:0] base_i,
   input  logic [CNT_W-1:0] step_i,
   output logic [IDX_W-1:0] sum_o
);
   localparam int SW   = ((CNT_W > IDX_W) ? CNT_W : IDX_W) + 1;
   localparam bit POW2 = ((N & (N - 1)) == 0);

   logic [SW-1:0] raw;
   assign raw = SW'(base_i) + SW'(step_i);

   generate
      if (POW2) begin : g_pow2
         assign sum_o = raw[IDX_W-1:0];
      end else begin : g_cmp
         logic [SW-1:0] red;
         assign red   = (raw >= SW'(N)) ? (raw - SW'(N)) : raw;
         assign sum_o = red[IDX_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/rsfm_next.sv
module rsfm_next
   import rsfm_pkg::*;
#(
   parameter int N     = 96,
   parameter int IDX_W = 7,
   parameter int CNT_W = 7,
   parameter int IMM_W = 7
) (
   input  logic [2:0]       op_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [CNT_W-1:0] a_sof_i,
   input  logic [CNT_W-1:0] a_sol_i,
   input  logic [CNT_W-1:0] a_sor_i,
   input  logic [CNT_W-1:0] cur_sof_i,
   input  logic [CNT_W-1:0] cur_sol_i,
   input  logic [CNT_W-1:0] cur_sor_i,
   input  logic [IDX_W-1:0] cur_base_i,
   input  logic [CNT_W-1:0] prv_sof_i,
   input  logic [CNT_W-1:0] prv_sol_i,
   input  logic [CNT_W-1:0] prv_sor_i,
   input  logic [IDX_W-1:0] prv_base_i,
   output logic [CNT_W-1:0] nxt_sof_o,
   output logic [CNT_W-1:0] nxt_sol_o,
   output logic [CNT_W-1:0] nxt_sor_o,
   output logic [IDX_W-1:0] nxt_base_o,
   output logic [IDX_W-1:0] nxt_tos_o,
   output logic             fault_o,
   output logic             save_o
);
   localparam int GW = ((CNT_W > IMM_W) ? CNT_W : IMM_W) + 1;

   logic [IDX_W-1:0] call_base;
   logic [GW-1:0]    grow_sum;
   logic [CNT_W-1:0] shrunk;
   rsfm_op_e         op;

   assign op       = rsfm_op_e'(op_i);
   assign grow_sum = GW'(cur_sof_i) + GW'(imm_i);
   assign shrunk   = cur_sof_i - CNT_W'(imm_i);

   rsfm_wrap_add #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_call_base (
      .base_i (cur_base_i),
      .step_i (cur_sol_i),
      .sum_o  (call_base)
   );

   always_comb begin
      nxt_sof_o  = cur_sof_i;
      nxt_sol_o  = cur_sol_i;
      nxt_sor_o  = cur_sor_i;
      nxt_base_o = cur_base_i;
      fault_o    = 1'b0;
      save_o     = 1'b0;
      case (op)
         OP_ALLOC: begin
            if ((a_sol_i > a_sof_i) || (a_sor_i > a_sof_i) || (a_sof_i > CNT_W'(N))) begin
               fault_o = 1'b1;
            end else begin
               nxt_sof_o = a_sof_i;
               nxt_sol_o = a_sol_i;
               nxt_sor_o = a_sor_i;
            end
         end
         OP_CALL: begin
            save_o     = 1'b1;
            nxt_base_o = call_base;
            nxt_sof_o  = cur_sof_i - cur_sol_i;
            nxt_sol_o  = '0;
            nxt_sor_o  = '0;
         end
         OP_RET: begin
            nxt_sof_o  = prv_sof_i;
            nxt_sol_o  = prv_sol_i;
            nxt_sor_o  = prv_sor_i;
            nxt_base_o = prv_base_i;
         end
         OP_GROW: begin
            if (grow_sum > GW'(N)) fault_o = 1'b1;
            else                   nxt_sof_o = grow_sum[CNT_W-1:0];
         end
         OP_SHRINK: begin
            if (GW'(imm_i) > GW'(cur_sof_i)) begin
               fault_o = 1'b1;
            end else begin
               nxt_sof_o = shrunk;
               nxt_sol_o = (cur_sol_i > shrunk) ? shrunk : cur_sol_i;
               nxt_sor_o = (cur_sor_i > shrunk) ? shrunk : cur_sor_i;
            end
         end
         default: fault_o = 1'b1;
      endcase
   end

   rsfm_wrap_add #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tos (
      .base_i (nxt_base_o),
      .step_i (nxt_sof_o),
      .sum_o  (nxt_tos_o)
   );

endmodule

// File: rtl/rsfm_marker_reg.sv
module rsfm_marker_reg #(
   parameter int N     = 96,
   parameter int IDX_W = 7,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             fault_i,
   input  logic             save_i,
   input  logic [CNT_W-1:0] nxt_sof_i,
   input  logic [CNT_W-1:0] nxt_sol_i,
   input  logic [CNT_W-1:0] nxt_sor_i,
   input  logic [IDX_W-1:0] nxt_base_i,
   input  logic [IDX_W-1:0] nxt_tos_i,
   output logic             ready_o,
   output logic             rsp_valid_o,
   output logic             rsp_fault_o,
   output logic [CNT_W-1:0] cur_sof_o,
   output logic [CNT_W-1:0] cur_sol_o,
   output logic [CNT_W-1:0] cur_sor_o,
   output logic [IDX_W-1:0] cur_base_o,
   output logic [IDX_W-1:0] cur_tos_o,
   output logic [CNT_W-1:0] prv_sof_o,
   output logic [CNT_W-1:0] prv_sol_o,
   output logic [CNT_W-1:0] prv_sor_o,
   output logic [IDX_W-1:0] prv_base_o
);
   logic commit;
   assign commit = accept_i && !fault_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_o     <= 1'b0;
         rsp_valid_o <= 1'b0;
         rsp_fault_o <= 1'b0;
         cur_sof_o   <= '0;
         cur_sol_o   <= '0;
         cur_sor_o   <= '0;
         cur_base_o  <= '0;
         cur_tos_o   <= '0;
         prv_sof_o   <= '0;
         prv_sol_o   <= '0;
         prv_sor_o   <= '0;
         prv_base_o  <= '0;
      end else begin
         ready_o     <= 1'b1;
         rsp_valid_o <= accept_i;
         rsp_fault_o <= accept_i && fault_i;
         if (commit) begin
            cur_sof_o  <= nxt_sof_i;
            cur_sol_o  <= nxt_sol_i;
            cur_sor_o  <= nxt_sor_i;
            cur_base_o <= nxt_base_i;
            cur_tos_o  <= nxt_tos_i;
         end
         if (commit && save_i) begin
            prv_sof_o  <= cur_sof_o;
            prv_sol_o  <= cur_sol_o;
            prv_sor_o  <= cur_sor_o;
            prv_base_o <= cur_base_o;
         end
      end
   end

   assert_fault_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_fault_o) |->
         ($stable(cur_sof_o) && $stable(cur_sol_o) && $stable(cur_sor_o) &&
          $stable(cur_base_o) && $stable(prv_sof_o) && $stable(prv_base_o)));

   assert_sof_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cur_sof_o <= CNT_W'(N));

   assert_fields_within_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_sol_o <= cur_sof_o) && (cur_sor_o <= cur_sof_o));

   assert_tos_relation_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cur_tos_o) == ((int'(cur_base_o) + int'(cur_sof_o)) % N)));

   assert_base_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_base_o) < N);

endmodule

// File: rtl/rsfm_unit.sv
module rsfm_unit
   import rsfm_pkg::*;
#(
   parameter int STACK_REGS = 96,
   parameter int IMM_W      = 7,
   parameter int CNT_W      = $clog2(STACK_REGS + 1),
   parameter int IDX_W      = $clog2(STACK_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic [IMM_W-1:0] cmd_imm,
   input  logic [CNT_W-1:0] cmd_sof,
   input  logic [CNT_W-1:0] cmd_sol,
   input  logic [CNT_W-1:0] cmd_sor,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [CNT_W-1:0] frame_sof,
   output logic [CNT_W-1:0] frame_sol,
   output logic [CNT_W-1:0] frame_sor,
   output logic [IDX_W-1:0] frame_base,
   output logic [IDX_W-1:0] frame_tos,
   output logic [CNT_W-1:0] pfs_sof,
   output logic [CNT_W-1:0] pfs_sol,
   output logic [CNT_W-1:0] pfs_sor,
   output logic [IDX_W-1:0] pfs_base
);
   generate
      if (STACK_REGS < 2) begin : g_bad_size
         $error("rsfm_unit: STACK_REGS must be at least 2");
      end
      if (IMM_W < 1) begin : g_bad_imm
         $error("rsfm_unit: IMM_W must be at least 1");
      end
      if ((1 << CNT_W) <= STACK_REGS) begin : g_bad_cnt
         $error("rsfm_unit: CNT_W cannot hold STACK_REGS");
      end
      if ((1 << IDX_W) < STACK_REGS) begin : g_bad_idx
         $error("rsfm_unit: IDX_W cannot index STACK_REGS");
      end
   endgenerate

   logic             accept;
   logic             fault;
   logic             save;
   logic [CNT_W-1:0] n_sof, n_sol, n_sor;
   logic [IDX_W-1:0] n_base, n_tos;

   assign accept = cmd_valid && cmd_ready;

   rsfm_next #(.N(STACK_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_next (
      .op_i       (cmd_op),
      .imm_i      (cmd_imm),
      .a_sof_i    (cmd_sof),
      .a_sol_i    (cmd_sol),
      .a_sor_i    (cmd_sor),
      .cur_sof_i  (frame_sof),
      .cur_sol_i  (frame_sol),
      .cur_sor_i  (frame_sor),
      .cur_base_i (frame_base),
      .prv_sof_i  (pfs_sof),
      .prv_sol_i  (pfs_sol),
      .prv_sor_i  (pfs_sor),
      .prv_base_i (pfs_base),
      .nxt_sof_o  (n_sof),
      .nxt_sol_o  (n_sol),
      .nxt_sor_o  (n_sor),
      .nxt_base_o (n_base),
      .nxt_tos_o  (n_tos),
      .fault_o    (fault),
      .save_o     (save)
   );

   rsfm_marker_reg #(.N(STACK_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .fault_i     (fault),
      .save_i      (save),
      .nxt_sof_i   (n_sof),
      .nxt_sol_i   (n_sol),
      .nxt_sor_i   (n_sor),
      .nxt_base_i  (n_base),
      .nxt_tos_i   (n_tos),
      .ready_o     (cmd_ready),
      .rsp_valid_o (rsp_valid),
      .rsp_fault_o (rsp_fault),
      .cur_sof_o   (frame_sof),
      .cur_sol_o   (frame_sol),
      .cur_sor_o   (frame_sor),
      .cur_base_o  (frame_base),
      .cur_tos_o   (frame_tos),
      .prv_sof_o   (pfs_sof),
      .prv_sol_o   (pfs_sol),
      .prv_sor_o   (pfs_sor),
      .prv_base_o  (pfs_base)
   );

   assert_rsp_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);

   assert_no_rsp_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !rsp_valid);

   assert_call_saves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_op == OP_CALL) |=>
         (pfs_sof == $past(frame_sof) && pfs_sol == $past(frame_sol) &&
          pfs_base == $past(frame_base) && frame_sol == '0));

   assert_ret_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_op == OP_RET) |=>
         (!rsp_fault && frame_sof == $past(pfs_sof) && frame_base == $past(pfs_base)));

   assert_undef_faults_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_op > 3'd4) |=> rsp_fault);

endmodule

// File: tb/rsfm_unit_tb_top.sv
module rsfm_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 96;
   localparam int CW = 7;
   localparam int AW = 7;

   typedef struct {
      logic [63:0] v;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = '0;
   logic [6:0]    cmd_imm = '0;
   logic [CW-1:0] cmd_sof = '0, cmd_sol = '0, cmd_sor = '0;
   logic          rsp_valid, rsp_fault;
   logic [CW-1:0] frame_sof, frame_sol, frame_sor, pfs_sof, pfs_sol, pfs_sor;
   logic [AW-1:0] frame_base, frame_tos, pfs_base;

   int checks = 0;
   int errors = 0;
   exp_t exp_q[$];

   int m_sof = 0, m_sol = 0, m_sor = 0, m_base = 0;
   int p_sof = 0, p_sol = 0, p_sor = 0, p_base = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsfm_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_imm(cmd_imm), .cmd_sof(cmd_sof), .cmd_sol(cmd_sol),
      .cmd_sor(cmd_sor), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .frame_sof(frame_sof), .frame_sol(frame_sol), .frame_sor(frame_sor),
      .frame_base(frame_base), .frame_tos(frame_tos), .pfs_sof(pfs_sof),
      .pfs_sol(pfs_sol), .pfs_sor(pfs_sor), .pfs_base(pfs_base)
   );

   function automatic logic [63:0] pack(logic f, int s, int l, int r, int b, int t,
                                        int ps, int pl, int pr, int pb);
      return {1'b0, f, CW'(s), CW'(l), CW'(r), AW'(b), AW'(t), CW'(ps), CW'(pl), CW'(pr), AW'(pb)};
   endfunction

   function automatic logic [63:0] observed();
      return {1'b0, rsp_fault, frame_sof, frame_sol, frame_sor, frame_base, frame_tos,
              pfs_sof, pfs_sol, pfs_sor, pfs_base};
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Driver: applies one command, updates the reference model, queues the expectation
   task automatic do_cmd(string tag, int op, int imm, int s, int l, int r);
      logic f;
      exp_t e;
      f = 1'b0;
      case (op)
         0: if (l > s || r > s || s > NREG) f = 1'b1;
            else begin m_sof = s; m_sol = l; m_sor = r; end
         1: begin
            p_sof = m_sof; p_sol = m_sol; p_sor = m_sor; p_base = m_base;
            m_base = (m_base + m_sol) % NREG;
            m_sof = m_sof - m_sol; m_sol = 0; m_sor = 0;
         end
         2: begin m_sof = p_sof; m_sol = p_sol; m_sor = p_sor; m_base = p_base; end
         3: if (m_sof + imm > NREG) f = 1'b1; else m_sof = m_sof + imm;
         4: if (imm > m_sof) f = 1'b1;
            else begin
               m_sof = m_sof - imm;
               if (m_sol > m_sof) m_sol = m_sof;
               if (m_sor > m_sof) m_sor = m_sof;
            end
         default: f = 1'b1;
      endcase
      e.v = pack(f, m_sof, m_sol, m_sor, m_base, (m_base + m_sof) % NREG,
                 p_sof, p_sol, p_sor, p_base);
      e.tag = tag;
      while (!cmd_ready) @(negedge clk);
      cmd_op = 3'(op); cmd_imm = 7'(imm);
      cmd_sof = CW'(s); cmd_sol = CW'(l); cmd_sor = CW'(r);
      cmd_valid = 1'b1;
      exp_q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Monitor: compares each response with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("R11 unexpected response", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, observed(), e.v);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset marker", observed(), 64'd0);
      check("R1 ready and idle", {62'd0, cmd_ready, rsp_valid}, 64'd2);

      do_cmd("R2 allocate 20/16/0", 0, 0, 20, 16, 0);
      do_cmd("R3 locals above frame", 0, 0, 10, 12, 0);
      do_cmd("R3 frame above 96", 0, 0, 97, 0, 0);
      do_cmd("R3 rotating above frame", 0, 0, 10, 4, 11);
      do_cmd("R5 grow 3", 3, 3, 0, 0, 0);
      do_cmd("R5 grow to exactly 96", 3, 73, 0, 0, 0);
      do_cmd("R5 grow past 96", 3, 1, 0, 0, 0);
      do_cmd("R7 shrink clamps locals", 4, 90, 0, 0, 0);
      do_cmd("R6 shrink below zero", 4, 7, 0, 0, 0);
      do_cmd("R6 shrink to zero", 4, 6, 0, 0, 0);
      do_cmd("R2 allocate 30/20/8", 0, 0, 30, 20, 8);
      do_cmd("R4 call saves marker", 1, 0, 0, 0, 0);
      do_cmd("R8 return restores", 2, 0, 0, 0, 0);
      do_cmd("R2 allocate 90/80/0", 0, 0, 90, 80, 0);
      do_cmd("R4 call to base 80", 1, 0, 0, 0, 0);
      do_cmd("R2 allocate 40/30/5", 0, 0, 40, 30, 5);
      do_cmd("R9 call wraps base", 1, 0, 0, 0, 0);
      do_cmd("R5 grow by 127", 3, 127, 0, 0, 0);
      do_cmd("R10 opcode 5", 5, 0, 1, 1, 1);
      do_cmd("R10 opcode 6", 6, 0, 0, 0, 0);
      do_cmd("R10 opcode 7", 7, 1, 0, 0, 0);
      do_cmd("R8 return after wrap", 2, 0, 0, 0, 0);
      do_cmd("R7 shrink clamps rotating", 4, 36, 0, 0, 0);
      do_cmd("R9 grow across region end", 3, 60, 0, 0, 0);

      repeat (6) @(negedge clk);
      // R11: every command answered once, no stray responses while idle
      check("R11 all responses seen", 64'(exp_q.size()), 64'd0);
      check("R11 idle output", {63'd0, rsp_valid}, 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule